// File: doc/BRIEF.md
# Programmable Dual Match and Transition Channel Event Logic

This block holds the event state of one timer channel. Two match units each compare a stored value with their own time base, and two transition inputs arrive as single-cycle pulses from an upstream filtered edge detector. For each unit the block keeps a match-enable flag, a match-event flag and a transition-event flag. It also holds two capture registers and one service request line.

A 15-bit mode word sets every interaction between these events. It decides which events block or enable which others, whether the two transitions must occur in order, which events load the capture registers, and which event raises the service request. Software can therefore build custom channel behaviours without new logic. The flags are cleared through small command fields, and the request stays up until software has cleared every event flag.

All state is registered. A match is detected combinationally in the cycle where the time base equals the stored value, and its effects appear after the next rising clock edge. In any one cycle, a new event that sets a flag takes priority over a clear command for the same flag, and a value write to a unit takes priority over that unit's self-clear.

Top module: `chan_evt_top`

## Requirements
- R1: After reset, all six flags, the service request and both capture registers read zero.
- R2: A value write to a unit sets its enable flag. While a unit is enabled, its time base equals its value and its gate is open, the unit sets its match-event flag and clears its own enable flag. Unit A compares against time base A, and unit B against time base B.
- R3: Mode bit 8 makes a match B event clear enable A. Mode bit 7 makes a match A event clear enable B.
- R4: When mode bit 6 is set, match B is blocked until the match-event A flag is set. When bits 6 and 7 are both set, match B is always blocked.
- R5: When mode bit 5 is set, transitions are ignored until the match-event A flag is set. When mode bit 9 is set, transitions are ignored while the match-event B flag is set.
- R6: Mode bit 10 blocks match A while transition flag A is set, and bit 11 blocks it while transition flag B is set. Match B is blocked while the transition flag picked by bit 12 is set (0 selects A, 1 selects B).
- R7: When mode bit 13 is set, transition B is ignored until transition flag A is set. When the bit is clear, the two transitions are recorded in either order.
- R8: Mode bits 1:0 choose when a match raises the request: 00 never, 01 on a match B event, 10 on whichever match event comes second in time, 11 on any match event.
- R9: Mode bit 2 clear raises the request on the first transition in time, which is an event while neither transition flag is set. Bit 2 set raises it on the second transition in time.
- R10: With mode bit 3 clear, each transition event loads its own capture register from its own time base. With bit 3 set, the second transition loads both registers. With mode bit 4 clear, each match event loads its own register. With bit 4 set, any match event loads both registers.
- R11: A match never loads a capture register that a transition has loaded since that unit's transition flag was last cleared. A transition always loads its capture register, whether or not a match wrote it before.
- R12: When mode bit 14 is set, each further qualifying edge on transition input A, after transition flag A is set, reloads capture register A from time base A. When bit 14 is clear, capture register A is held.
- R13: The transition-flag clear code clears A on 00, B on 01, both on 10 and neither on 11. The enable-flag clear code clears A on 00, both on 01, B on 10 and neither on 11. The match-flag clear input is a per-unit mask, with bit 0 for A and bit 1 for B.
- R14: The service request, once raised, stays set while any match-event or transition-event flag is set. It falls on the same edge that clears the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 15 | Mode word (bit fields listed in the requirements) |
| tbase_a | input | TB_W | Time base for unit A |
| tbase_b | input | TB_W | Time base for unit B |
| mval_wr_a | input | 1 | Write the match value of unit A |
| mval_wr_b | input | 1 | Write the match value of unit B |
| mval_a | input | TB_W | Match value for unit A |
| mval_b | input | TB_W | Match value for unit B |
| edge_a | input | 1 | Transition A detected (one-cycle pulse) |
| edge_b | input | 1 | Transition B detected (one-cycle pulse) |
| tflag_clr | input | 2 | Transition flag clear code |
| men_clr | input | 2 | Match enable clear code |
| mflag_clr | input | 2 | Match event flag clear mask |
| men_a | output | 1 | Match enable flag A |
| men_b | output | 1 | Match enable flag B |
| mflag_a | output | 1 | Match event flag A |
| mflag_b | output | 1 | Match event flag B |
| tflag_a | output | 1 | Transition event flag A |
| tflag_b | output | 1 | Transition event flag B |
| svc_req | output | 1 | Service request |
| cap_a | output | TB_W | Capture register A |
| cap_b | output | TB_W | Capture register B |

## Verification
The bench targets the lock that follows a match-A event in single-match mode. A design that gated match B only on the enable flag would match again after a fresh value write. It applies transitions B-then-A with and without ordering, where a design ignoring the order bit would record the early B edge. It stacks a match capture on top of a transition capture and the reverse, which exposes a design that lets the later writer win or that never lets a transition win. It also checks that the request holds while one flag remains set and falls on the very edge that clears the last flag. It walks every code of both clear commands, whose A/B/both encodings differ between the two fields.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;

  typedef struct packed {
    logic       cont_cap;      // 14
    logic       t1_en_t2;      // 13
    logic       tr_blk_m2_sel; // 12
    logic       t2_blk_m1;     // 11
    logic       t1_blk_m1;     // 10
    logic       m2_blk_tr;     // 9
    logic       m2_blk_m1;     // 8
    logic       m1_blk_m2;     // 7
    logic       m1_en_m2;      // 6
    logic       m1_en_tr;      // 5
    logic       mcap_both;     // 4
    logic       tcap_both;     // 3
    logic       tsr_second;    // 2
    logic [1:0] msr;           // 1:0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Transition flag clear command: one-hot style mask {B, A}
  function automatic logic [1:0] tflag_clear_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 2'b01;
      2'b01:   return 2'b10;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // Enable flag clear command uses a different code order
  function automatic logic [1:0] enable_clear_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // Service decision for match events; index 0 is unit A
  function automatic logic match_service(input logic [1:0] msr,
                                         input logic [1:0] hit,
                                         input logic [1:0] mev);
    case (msr)
      2'b00:   return 1'b0;
      2'b01:   return hit[1];
      2'b10:   return (hit[0] & (mev[1] | hit[1])) | (hit[1] & (mev[0] | hit[0]));
      default: return hit[0] | hit[1];
    endcase
  endfunction

endpackage

// File: rtl/chan_match_unit.sv
module chan_match_unit #(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [TB_W-1:0] val_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic            gate_i,
  input  logic            clr_i,
  output logic            en_o,
  output logic            hit_o
);

  logic [TB_W-1:0] val_q;
  logic            en_q;

  assign hit_o = en_q & gate_i & (tb_i == val_q);
  assign en_o  = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_i) val_q <= val_i;
      if (wr_i)               en_q <= 1'b1;
      else if (hit_o | clr_i) en_q <= 1'b0;
    end
  end

  // R2: a match disables its own unit unless rewritten in the same cycle
  p_self_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o && !wr_i |=> !en_o);

  // R2: a value write always leaves the unit enabled
  p_wr_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_o);

endmodule

// File: rtl/chan_cap_reg.sv
module chan_cap_reg #(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tr_wr_i,
  input  logic            m_wr_i,
  input  logic            clr_own_i,
  input  logic [TB_W-1:0] tb_i,
  output logic [TB_W-1:0] cap_o
);

  logic [TB_W-1:0] cap_q;
  logic            own_q;   // set while the value came from a transition

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      own_q <= 1'b0;
    end else if (tr_wr_i) begin
      cap_q <= tb_i;
      own_q <= 1'b1;
    end else begin
      if (m_wr_i && !own_q) cap_q <= tb_i;
      if (clr_own_i)        own_q <= 1'b0;
    end
  end

  assign cap_o = cap_q;

  // R11: a transition-owned value survives any match write
  p_tr_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    own_q && !tr_wr_i |=> $stable(cap_o));

  // R11: a transition write always lands
  p_tr_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tr_wr_i |=> cap_o == $past(tb_i));

endmodule

// File: rtl/chan_evt_top.sv
module chan_evt_top
  import chan_evt_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic [TB_W-1:0]   tbase_a,
  input  logic [TB_W-1:0]   tbase_b,
  input  logic              mval_wr_a,
  input  logic              mval_wr_b,
  input  logic [TB_W-1:0]   mval_a,
  input  logic [TB_W-1:0]   mval_b,
  input  logic              edge_a,
  input  logic              edge_b,
  input  logic [1:0]        tflag_clr,
  input  logic [1:0]        men_clr,
  input  logic [1:0]        mflag_clr,
  output logic              men_a,
  output logic              men_b,
  output logic              mflag_a,
  output logic              mflag_b,
  output logic              tflag_a,
  output logic              tflag_b,
  output logic              svc_req,
  output logic [TB_W-1:0]   cap_a,
  output logic [TB_W-1:0]   cap_b
);

  localparam int NU = 2;

  mode_t m;
  assign m = mode_t'(mode_cfg);

  logic [TB_W-1:0] tb  [NU];
  logic [TB_W-1:0] val [NU];
  logic [TB_W-1:0] cap [NU];
  logic [NU-1:0] wr, men, hit, gate_m, xblk, en_kill, tclr, eclr;
  logic [NU-1:0] mev_q, tev_q, mev_nxt, tev_nxt, ev, tr_wr, m_wr;
  logic          tr_open, m2_lock, cont_a, t_first, t_second, svc_set, svc_q, svc_nxt;

  assign tb[0]  = tbase_a;   assign tb[1]  = tbase_b;
  assign val[0] = mval_a;    assign val[1] = mval_b;
  assign wr     = {mval_wr_b, mval_wr_a};
  assign tclr   = tflag_clear_mask(tflag_clr);
  assign eclr   = enable_clear_mask(men_clr);

  // Match gating by transitions and by the other match
  assign m2_lock   = m.m1_en_m2 & (m.m1_blk_m2 | ~mev_q[0]);
  assign gate_m[0] = ~(m.t1_blk_m1 & tev_q[0]) & ~(m.t2_blk_m1 & tev_q[1]);
  assign gate_m[1] = ~m2_lock & ~tev_q[m.tr_blk_m2_sel];
  assign xblk[0]   = m.m2_blk_m1 & hit[1];
  assign xblk[1]   = m.m1_blk_m2 & hit[0];
  assign en_kill   = eclr | xblk;

  // Transition qualification
  assign tr_open  = (~m.m1_en_tr | mev_q[0]) & ~(m.m2_blk_tr & mev_q[1]);
  assign ev[0]    = edge_a & tr_open & ~tev_q[0];
  assign ev[1]    = edge_b & tr_open & ~tev_q[1] & (~m.t1_en_t2 | tev_q[0]);
  assign cont_a   = m.cont_cap & edge_a & tr_open & tev_q[0];
  assign t_first  = (ev[0] | ev[1]) & ~tev_q[0] & ~tev_q[1];
  assign t_second = (ev[0] & tev_q[1]) | (ev[1] & tev_q[0]) | (ev[0] & ev[1]);

  // Flag next state: a new event wins over a clear
  assign mev_nxt = hit | (mev_q & ~mflag_clr);
  assign tev_nxt = ev  | (tev_q & ~tclr);

  assign svc_set = match_service(m.msr, hit, mev_q) | (m.tsr_second ? t_second : t_first);
  assign svc_nxt = svc_set | (svc_q & (|{mev_nxt, tev_nxt}));

  // Capture strobes
  assign tr_wr[0] = (m.tcap_both ? t_second : ev[0]) | cont_a;
  assign tr_wr[1] =  m.tcap_both ? t_second : ev[1];
  assign m_wr[0]  =  m.mcap_both ? (|hit) : hit[0];
  assign m_wr[1]  =  m.mcap_both ? (|hit) : hit[1];

  for (genvar i = 0; i < NU; i++) begin : g_unit
    chan_match_unit #(.TB_W(TB_W)) u_match (
      .clk(clk), .rst_n(rst_n), .wr_i(wr[i]), .val_i(val[i]), .tb_i(tb[i]),
      .gate_i(gate_m[i]), .clr_i(en_kill[i]), .en_o(men[i]), .hit_o(hit[i]));
    chan_cap_reg #(.TB_W(TB_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .tr_wr_i(tr_wr[i]), .m_wr_i(m_wr[i]),
      .clr_own_i(tclr[i]), .tb_i(tb[i]), .cap_o(cap[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mev_q <= '0;
      tev_q <= '0;
      svc_q <= 1'b0;
    end else begin
      mev_q <= mev_nxt;
      tev_q <= tev_nxt;
      svc_q <= svc_nxt;
    end
  end

  assign men_a   = men[0];   assign men_b   = men[1];
  assign mflag_a = mev_q[0]; assign mflag_b = mev_q[1];
  assign tflag_a = tev_q[0]; assign tflag_b = tev_q[1];
  assign svc_req = svc_q;
  assign cap_a   = cap[0];   assign cap_b   = cap[1];

  // R14: the request never stands without an event flag behind it
  p_svc_backed_r14: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (mflag_a | mflag_b | tflag_a | tflag_b));

  // R14: the request holds while flags remain
  p_svc_holds_r14: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |=> svc_req || !(mflag_a | mflag_b | tflag_a | tflag_b));

  // R4: single-match mode never lets unit B fire
  p_m2_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m.m1_en_m2 && m.m1_blk_m2 |-> !hit[1]);

  // R5: transitions stay out until match A has occurred
  p_tr_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m.m1_en_tr && !mflag_a && !tflag_a |=> !tflag_a);

  // R7: in ordered mode B can only rise while A is already recorded
  p_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tflag_b) && $past(m.t1_en_t2) && $past(tflag_clr) == 2'b11 |-> tflag_a);

endmodule

// File: tb/test_chan_evt_top.sv
module test_chan_evt_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int TB_W = 24;
  localparam int B_TSR = 2, B_TCAP = 3, B_MCAP = 4, B_M1ETR = 5, B_M1EM2 = 6,
                 B_M1BM2 = 7, B_M2BM1 = 8, B_M2BTR = 9, B_T1BM1 = 10,
                 B_TSEL = 12, B_T1ET2 = 13, B_CONT = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] mode_cfg = '0;
  logic [TB_W-1:0] tbase_a = '0, tbase_b = '0, mval_a = '0, mval_b = '0;
  logic mval_wr_a = 0, mval_wr_b = 0, edge_a = 0, edge_b = 0;
  logic [1:0] tflag_clr = 2'b11, men_clr = 2'b11, mflag_clr = 2'b00;
  logic men_a, men_b, mflag_a, mflag_b, tflag_a, tflag_b, svc_req;
  logic [TB_W-1:0] cap_a, cap_b;

  chan_evt_top #(.TB_W(TB_W)) i_chan_evt_top (.*);

  always #4 clk = ~clk;   // 125 MHz

  typedef struct { string req; int kind; logic [31:0] exp; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [14:0] bt(input int b); return 15'(1) << b; endfunction
  function automatic logic [6:0] fl(input bit ea, eb, ma, mb, ta, tb_, sv);
    return {sv, tb_, ta, mb, ma, eb, ea};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
    mval_wr_a = 0; mval_wr_b = 0; edge_a = 0; edge_b = 0;
    tflag_clr = 2'b11; men_clr = 2'b11; mflag_clr = 2'b00;
  endtask
  task automatic expf(input string r, input logic [6:0] f); q.push_back('{r, 0, 32'(f)}); endtask
  task automatic expc(input string r, input int k, input logic [TB_W-1:0] v); q.push_back('{r, k, 32'(v)}); endtask

  // Monitor: pops expectations and compares against the ports
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 32'({svc_req, tflag_b, tflag_a, mflag_b, mflag_a, men_b, men_a});
        1: act = 32'(cap_a);
        default: act = 32'(cap_b);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    expf("R1", fl(0,0,0,0,0,0,0)); expc("R1", 1, 0); expc("R1", 2, 0);

    // R2 R8 R10 R14: single match A, request on any match
    mode_cfg = 15'd3; mval_a = 10; mval_wr_a = 1; tick(); expf("R2", fl(1,0,0,0,0,0,0));
    tbase_a = 10; tick(); expf("R2", fl(0,0,1,0,0,0,1)); expc("R10", 1, 10);
    tbase_a = 0; mflag_clr = 2'b01; tick(); expf("R14", fl(0,0,0,0,0,0,0));

    // R3 R8: match B blocks match A; request on second match
    mode_cfg = 15'd2 | bt(B_M2BM1); mval_a = 5; mval_b = 7; mval_wr_a = 1; mval_wr_b = 1;
    tick(); expf("R2", fl(1,1,0,0,0,0,0));
    tbase_b = 7; tick(); expf("R3", fl(0,0,0,1,0,0,0)); expc("R10", 2, 7);
    tbase_b = 0; tbase_a = 5; tick(); expf("R3", fl(0,0,0,1,0,0,0));
    tbase_a = 0; mflag_clr = 2'b10; mval_wr_a = 1; mval_wr_b = 1; tick(); expf("R13", fl(1,1,0,0,0,0,0));
    tbase_a = 5; tick(); expf("R8", fl(0,1,1,0,0,0,0));
    tbase_a = 0; tbase_b = 7; tick(); expf("R8", fl(0,0,1,1,0,0,1));
    tbase_b = 0; mflag_clr = 2'b01; tick(); expf("R14", fl(0,0,0,1,0,0,1));
    mflag_clr = 2'b10; tick(); expf("R14", fl(0,0,0,0,0,0,0));

    // R4: match A enables match B; then single-match lock
    mode_cfg = 15'd1 | bt(B_M1EM2); mval_a = 4; mval_b = 3; mval_wr_a = 1; mval_wr_b = 1;
    tick(); expf("R4", fl(1,1,0,0,0,0,0));
    tbase_b = 3; tick(); expf("R4", fl(1,1,0,0,0,0,0));
    tbase_a = 4; tick(); expf("R8", fl(0,1,1,0,0,0,0));
    tbase_a = 0; tick(); expf("R4", fl(0,0,1,1,0,0,1));
    tbase_b = 0; mflag_clr = 2'b11; tick(); expf("R14", fl(0,0,0,0,0,0,0));
    mode_cfg = 15'd3 | bt(B_M1EM2) | bt(B_M1BM2); mval_wr_a = 1; mval_wr_b = 1;
    tick(); expf("R4", fl(1,1,0,0,0,0,0));
    tbase_a = 4; tbase_b = 3; tick(); expf("R4", fl(0,0,1,0,0,0,1));
    mval_wr_b = 1; tick(); expf("R4", fl(0,1,1,0,0,0,1));
    tick(); expf("R4", fl(0,1,1,0,0,0,1));
    tbase_a = 0; tbase_b = 0; mflag_clr = 2'b11; men_clr = 2'b01; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R13: enable clear codes
    mode_cfg = '0; mval_wr_a = 1; mval_wr_b = 1; tick(); expf("R13", fl(1,1,0,0,0,0,0));
    men_clr = 2'b00; tick(); expf("R13", fl(0,1,0,0,0,0,0));
    mval_wr_a = 1; tick(); expf("R13", fl(1,1,0,0,0,0,0));
    men_clr = 2'b10; tick(); expf("R13", fl(1,0,0,0,0,0,0));
    men_clr = 2'b11; tick(); expf("R13", fl(1,0,0,0,0,0,0));
    men_clr = 2'b01; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R7 R9 R10 R13: unordered transitions, request on first
    tbase_a = 100; tbase_b = 200; edge_b = 1; tick(); expf("R7", fl(0,0,0,0,0,1,1)); expc("R10", 2, 200);
    tbase_a = 110; edge_a = 1; tick(); expf("R9", fl(0,0,0,0,1,1,1)); expc("R10", 1, 110);
    tflag_clr = 2'b00; tick(); expf("R13", fl(0,0,0,0,0,1,1));
    tflag_clr = 2'b11; tick(); expf("R13", fl(0,0,0,0,0,1,1));
    tflag_clr = 2'b01; tick(); expf("R13", fl(0,0,0,0,0,0,0));
    edge_a = 1; edge_b = 1; tick(); expf("R9", fl(0,0,0,0,1,1,1));
    tflag_clr = 2'b10; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R7: ordered transitions
    mode_cfg = bt(B_T1ET2); tbase_b = 210; edge_b = 1; tick(); expf("R7", fl(0,0,0,0,0,0,0)); expc("R7", 2, 200);
    tbase_a = 120; edge_a = 1; tick(); expf("R7", fl(0,0,0,0,1,0,1)); expc("R10", 1, 120);
    edge_b = 1; tick(); expf("R7", fl(0,0,0,0,1,1,1)); expc("R10", 2, 210);
    tflag_clr = 2'b10; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R9 R10: request and both captures on the second transition
    mode_cfg = bt(B_TSR) | bt(B_TCAP); tbase_a = 300; tbase_b = 400; edge_a = 1;
    tick(); expf("R9", fl(0,0,0,0,1,0,0)); expc("R10", 1, 120);
    tbase_a = 310; tbase_b = 410; edge_b = 1;
    tick(); expf("R9", fl(0,0,0,0,1,1,1)); expc("R10", 1, 310); expc("R10", 2, 410);
    tflag_clr = 2'b10; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R11 R10: capture priority, match captures both
    mode_cfg = 15'd3 | bt(B_MCAP) | bt(B_TSEL); tbase_a = 50; tbase_b = 0; edge_a = 1;
    tick(); expf("R9", fl(0,0,0,0,1,0,1)); expc("R10", 1, 50);
    mval_b = 60; mval_wr_b = 1; tick(); expf("R2", fl(0,1,0,0,1,0,1));
    tbase_b = 60; tick(); expf("R11", fl(0,0,0,1,1,0,1)); expc("R11", 1, 50); expc("R10", 2, 60);
    tflag_clr = 2'b10; mflag_clr = 2'b11; tick(); expf("R14", fl(0,0,0,0,0,0,0));
    mval_a = 70; mval_wr_a = 1; tick(); expf("R2", fl(1,0,0,0,0,0,0));
    tbase_a = 70; tbase_b = 65; tick(); expf("R10", fl(0,0,1,0,0,0,1)); expc("R10", 1, 70); expc("R10", 2, 65);
    tbase_a = 80; edge_a = 1; tick(); expf("R11", fl(0,0,1,0,1,0,1)); expc("R11", 1, 80);
    tflag_clr = 2'b10; mflag_clr = 2'b11; tbase_b = 0; tick(); expf("R14", fl(0,0,0,0,0,0,0));

    // R12: continuous capture on A
    mode_cfg = bt(B_CONT); tbase_a = 500; edge_a = 1; tick(); expc("R12", 1, 500);
    tbase_a = 520; edge_a = 1; tick(); expf("R12", fl(0,0,0,0,1,0,1)); expc("R12", 1, 520);
    mode_cfg = '0; tbase_a = 540; edge_a = 1; tick(); expc("R12", 1, 520);
    tflag_clr = 2'b10; tbase_a = 0; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R5: transitions gated by match A, blocked by match B
    mode_cfg = bt(B_M1ETR); edge_a = 1; tick(); expf("R5", fl(0,0,0,0,0,0,0));
    mval_a = 9; mval_wr_a = 1; tick(); expf("R2", fl(1,0,0,0,0,0,0));
    tbase_a = 9; tick(); expf("R2", fl(0,0,1,0,0,0,0));
    tbase_a = 0; edge_a = 1; tick(); expf("R5", fl(0,0,1,0,1,0,1));
    tflag_clr = 2'b10; mflag_clr = 2'b11; tick(); expf("R14", fl(0,0,0,0,0,0,0));
    mode_cfg = bt(B_M2BTR); mval_b = 2; mval_wr_b = 1; tick(); expf("R2", fl(0,1,0,0,0,0,0));
    tbase_b = 2; tick(); expf("R2", fl(0,0,0,1,0,0,0));
    tbase_b = 0; edge_a = 1; tick(); expf("R5", fl(0,0,0,1,0,0,0));
    mflag_clr = 2'b11; tick(); expf("R13", fl(0,0,0,0,0,0,0));

    // R6: transitions blocking matches
    mode_cfg = bt(B_T1BM1); edge_a = 1; tick(); expf("R9", fl(0,0,0,0,1,0,1));
    mval_a = 11; mval_wr_a = 1; tick(); expf("R6", fl(1,0,0,0,1,0,1));
    tbase_a = 11; tick(); expf("R6", fl(1,0,0,0,1,0,1));
    tflag_clr = 2'b00; tick(); expf("R6", fl(1,0,0,0,0,0,0));
    tick(); expf("R6", fl(0,0,1,0,0,0,0));
    tbase_a = 0; mflag_clr = 2'b11; tick(); expf("R13", fl(0,0,0,0,0,0,0));
    mode_cfg = bt(B_TSEL); edge_b = 1; tick(); expf("R9", fl(0,0,0,0,0,1,1));
    mval_b = 12; mval_wr_b = 1; tick(); expf("R6", fl(0,1,0,0,0,1,1));
    tbase_b = 12; tick(); expf("R6", fl(0,1,0,0,0,1,1));
    tflag_clr = 2'b01; tick(); expf("R6", fl(0,1,0,0,0,0,0));
    tick(); expf("R6", fl(0,0,0,1,0,0,0));

    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule